// File: doc/BRIEF.md
# Descriptor Ring Poll Scheduler

This block tells a network DMA engine when to fetch a ring descriptor and check whether software has handed it over. It keeps an interval counter that counts down only while the engine sits in its idle poll-counting state. It also watches the cached ownership flags for the receive and transmit descriptors, the path enables, a transmit auto-poll inhibit, pulses for completed frames and a host transmit-demand strobe. From these it decides whether a receive poll, a transmit poll or both are due.

Requests go to a descriptor-fetch interface one at a time. The receive poll always comes before the transmit poll, and each request is held until a one-cycle done pulse comes back. A demand strobe cuts the count short and polls at once. A demand or frame event that arrives while the engine is busy is held and served when the engine becomes idle again. Once a sequence completes, the counter restarts from the programmed interval.

Top module: `desc_poll_sched`

## Requirements
- R1: After reset `poll_req` is 0 and the interval register holds 0. With receive enabled and the current receive descriptor not owned, the first timed receive poll is raised on the 65,536th clock edge after reset is released.
- R2: A write of N (1 to 65,535) through `ivl_wr`/`ivl_wdata` takes effect at the next reload. The following timed poll is raised on the Nth idle clock edge after the edge on which the previous sequence ended. The value 0 means 65,536.
- R3: When the interval expires, a receive poll (`poll_is_tx`=0) is issued if `rx_en`=1 and `rx_cur_own`=0.
- R4: When the interval expires, a receive poll is also issued if `rx_en`=1, `rx_nxt_own`=0 and `rx_ring_multi`=1. With `rx_ring_multi`=0 the next-descriptor flag alone triggers nothing.
- R5: While `rx_en`=0 no receive poll is ever launched.
- R6: When the interval expires, a transmit poll (`poll_is_tx`=1) is issued if `tx_en`=1, `tx_poll_off`=0 and `tx_cur_own`=0. With `tx_poll_off`=1 no timed transmit poll occurs.
- R7: A `rx_frame_done` or `tx_frame_done` pulse launches a transmit poll on the next edge under the same conditions as R6, without waiting for the interval.
- R8: When both polls are due in one sequence, the receive request is served first and the transmit request follows on the edge after its done pulse.
- R9: A `tx_demand` pulse while idle launches a poll on the next edge. It includes a receive poll first if `rx_en`=1 and `rx_cur_own`=0, then a transmit poll if `tx_en`=1 and `tx_cur_own`=0, whatever the value of `tx_poll_off`.
- R10: While `engine_busy`=1 the counter is frozen and nothing is launched. A demand or frame event seen meanwhile is kept and served on the first edge after `engine_busy` falls.
- R11: `poll_req` and `poll_is_tx` stay unchanged until `poll_done` is seen. Only one request is outstanding at a time, and `poll_req` falls on the edge after the last done of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ivl_wr | input | 1 | Write strobe for the interval register |
| ivl_wdata | input | CNT_W | Interval value in clocks, 0 = 2^CNT_W |
| rx_en | input | 1 | Receive path enabled |
| tx_en | input | 1 | Transmit path enabled |
| tx_poll_off | input | 1 | Inhibit timed and event-driven transmit polls |
| rx_cur_own | input | 1 | Engine owns current receive descriptor |
| rx_nxt_own | input | 1 | Engine owns next receive descriptor |
| rx_ring_multi | input | 1 | Receive ring has more than one descriptor |
| tx_cur_own | input | 1 | Engine owns current transmit descriptor |
| rx_frame_done | input | 1 | Pulse: a frame was received |
| tx_frame_done | input | 1 | Pulse: a frame was transmitted |
| tx_demand | input | 1 | Pulse: host requests an immediate poll |
| engine_busy | input | 1 | Engine is outside its poll-counting state |
| poll_req | output | 1 | Poll request to descriptor fetch |
| poll_is_tx | output | 1 | 0 = receive descriptor, 1 = transmit descriptor |
| poll_done | input | 1 | One-cycle pulse: current poll finished |

## Verification
The hardest case to reach is a host demand that arrives while the engine is busy. The stimulus holds `engine_busy` high for many cycles and pulses `tx_demand` inside that window. It then confirms that no request appears, drops busy, and expects the request on the very next edge. The 65,536-cycle default interval is measured once in full from reset. Every other timed case first programs a short interval and lets it take effect through a completed sequence, so each expiry lands on a known edge.

// File: rtl/dps_pkg.sv
// Package: shared types for the descriptor ring poll scheduler.
// Assumes nothing beyond IEEE 1800-2017 synthesizable types.
package dps_pkg;

    // Sequencer states: counting the interval, or serving a poll request.
    typedef enum logic [1:0] {
        ST_COUNT = 2'd0,
        ST_RX    = 2'd1,
        ST_TX    = 2'd2
    } seq_state_t;

endpackage

// File: rtl/dps_interval.sv
// Module: dps_interval
// Holds the writable poll interval and the down-counter that measures it.
// The counter runs only while count_en is high. It raises tick on the last
// counting cycle and reloads whenever reload is high. A stored interval of 0
// stands for 2^CNT_W cycles. Assumes reload is asserted on tick by the caller.
module dps_interval #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ivl_wr,
    input  logic [CNT_W-1:0] ivl_wdata,
    input  logic             count_en,
    input  logic             reload,
    output logic             tick
);
    localparam int CW = CNT_W + 1;
    localparam logic [CW-1:0] FULL = {1'b1, {CNT_W{1'b0}}};
    localparam logic [CW-1:0] ONE  = {{CNT_W{1'b0}}, 1'b1};

    logic [CNT_W-1:0] ivl_q;
    logic [CW-1:0]    cnt_q;
    logic [CW-1:0]    reload_val;

    // Interval register: host-written, cleared by reset (meaning full range).
    always_ff @(posedge clk) begin
        if (!rst_n)
            ivl_q <= '0;
        else if (ivl_wr)
            ivl_q <= ivl_wdata;
    end

    // Map the stored value to a cycle count, 0 selecting the maximum.
    always_comb begin
        reload_val = (ivl_q == '0) ? FULL : {1'b0, ivl_q};
    end

    // Expiry is the last counting cycle of the interval.
    always_comb begin
        tick = count_en && (cnt_q == ONE);
    end

    // Down-counter: reload on request, otherwise count while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= FULL;
        else if (reload)
            cnt_q <= reload_val;
        else if (count_en)
            cnt_q <= cnt_q - ONE;
    end

    // The counter never reaches zero, so an expiry is never skipped.
    assert_cnt_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != '0);

    // A counting cycle with no reload always moves the counter down by one.
    assert_cnt_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !reload) |=> (cnt_q == $past(cnt_q) - ONE));

endmodule

// File: rtl/dps_trigger.sv
// Module: dps_trigger
// Gathers the three poll sources (interval expiry, frame events, host
// demand) and works out which polls a new sequence needs. Events and
// demands that arrive while not idle are latched until the next idle cycle.
// Assumes idle is high only while the sequencer counts and the engine is free.
module dps_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic idle,
    input  logic tick,
    input  logic rx_en,
    input  logic tx_en,
    input  logic tx_poll_off,
    input  logic rx_cur_own,
    input  logic rx_nxt_own,
    input  logic rx_ring_multi,
    input  logic tx_cur_own,
    input  logic rx_frame_done,
    input  logic tx_frame_done,
    input  logic tx_demand,
    output logic launch,
    output logic go_rx,
    output logic go_tx,
    output logic dem_hit
);
    logic dem_pend_q;
    logic evt_pend_q;
    logic dem_now;
    logic evt_now;
    logic fire;
    logic rx_timed;
    logic rx_demand;
    logic tx_auto;
    logic tx_forced;

    // Merge live strobes with latched ones.
    always_comb begin
        dem_now = dem_pend_q || tx_demand;
        evt_now = evt_pend_q || rx_frame_done || tx_frame_done;
    end

    // Ownership-based conditions for each kind of poll.
    always_comb begin
        rx_timed  = rx_en && (!rx_cur_own || (!rx_nxt_own && rx_ring_multi));
        rx_demand = rx_en && !rx_cur_own;
        tx_auto   = tx_en && !tx_poll_off && !tx_cur_own;
        tx_forced = tx_en && !tx_cur_own;
    end

    // Decide, on an idle cycle, which polls the sequence must carry.
    always_comb begin
        fire    = idle && (tick || dem_now || evt_now);
        go_rx   = idle && ((tick && rx_timed) || (dem_now && rx_demand));
        go_tx   = idle && (((tick || evt_now) && tx_auto) || (dem_now && tx_forced));
        launch  = fire && (go_rx || go_tx);
        dem_hit = idle && dem_now;
    end

    // Pending latches: set by strobes, cleared when an idle cycle consumes them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dem_pend_q <= 1'b0;
            evt_pend_q <= 1'b0;
        end else if (fire) begin
            dem_pend_q <= 1'b0;
            evt_pend_q <= 1'b0;
        end else begin
            dem_pend_q <= dem_pend_q || tx_demand;
            evt_pend_q <= evt_pend_q || rx_frame_done || tx_frame_done;
        end
    end

    // A demand that is waiting is dropped only by an idle cycle.
    assert_dem_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dem_pend_q && !idle) |=> dem_pend_q);

endmodule

// File: rtl/dps_sequencer.sv
// Module: dps_sequencer
// Runs a poll sequence: an optional receive request followed by an optional
// transmit request. Each is held until a done pulse. It reports idle
// (counting state, engine free) and the end of each sequence.
// Assumes poll_done is only pulsed while a request is outstanding.
module dps_sequencer
    import dps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic engine_busy,
    input  logic rx_en,
    input  logic launch,
    input  logic go_rx,
    input  logic go_tx,
    input  logic poll_done,
    output logic idle,
    output logic seq_end,
    output logic poll_req,
    output logic poll_is_tx
);
    seq_state_t state_q;
    logic       tx_next_q;

    // Idle means counting with the engine free.
    always_comb begin
        idle = (state_q == ST_COUNT) && !engine_busy;
    end

    // Sequence completes on done of its last request.
    always_comb begin
        seq_end = poll_done &&
                  ((state_q == ST_TX) || ((state_q == ST_RX) && !tx_next_q));
    end

    // Request outputs follow the state directly.
    always_comb begin
        poll_req   = (state_q != ST_COUNT);
        poll_is_tx = (state_q == ST_TX);
    end

    // State machine: launch into RX or TX, step RX to TX, return to counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_COUNT;
            tx_next_q <= 1'b0;
        end else begin
            case (state_q)
                ST_COUNT: begin
                    if (launch) begin
                        state_q   <= go_rx ? ST_RX : ST_TX;
                        tx_next_q <= go_rx && go_tx;
                    end
                end
                ST_RX: begin
                    if (poll_done) begin
                        state_q   <= tx_next_q ? ST_TX : ST_COUNT;
                        tx_next_q <= 1'b0;
                    end
                end
                ST_TX: begin
                    if (poll_done)
                        state_q <= ST_COUNT;
                end
                default: state_q <= ST_COUNT;
            endcase
        end
    end

    // Request and its direction stay put until done arrives.
    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_req && !poll_done) |=> (poll_req && $stable(poll_is_tx)));

    // A fresh receive request only follows a cycle with receive enabled.
    assert_no_rx_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_req && !poll_is_tx && !$past(poll_req)) |-> $past(rx_en));

    // Nothing is launched while the engine is busy.
    assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (engine_busy && !poll_req) |=> !poll_req);

    // Receive done with a transmit queued moves straight to the transmit request.
    assert_rx_then_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_req && !poll_is_tx && poll_done && tx_next_q) |=> (poll_req && poll_is_tx));

endmodule

// File: rtl/desc_poll_sched.sv
// Module: desc_poll_sched (top)
// Descriptor ring poll scheduler: interval timer, trigger evaluation and
// request sequencer. Assumes poll_done is a single-cycle pulse answering the
// outstanding request, and that all inputs are synchronous to clk.
module desc_poll_sched #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ivl_wr,
    input  logic [CNT_W-1:0] ivl_wdata,
    input  logic             rx_en,
    input  logic             tx_en,
    input  logic             tx_poll_off,
    input  logic             rx_cur_own,
    input  logic             rx_nxt_own,
    input  logic             rx_ring_multi,
    input  logic             tx_cur_own,
    input  logic             rx_frame_done,
    input  logic             tx_frame_done,
    input  logic             tx_demand,
    input  logic             engine_busy,
    output logic             poll_req,
    output logic             poll_is_tx,
    input  logic             poll_done
);
    logic idle;
    logic tick;
    logic launch;
    logic go_rx;
    logic go_tx;
    logic dem_hit;
    logic seq_end;
    logic reload;

    // Restart the interval on expiry, demand, launch or end of a sequence.
    always_comb begin
        reload = tick || dem_hit || launch || seq_end;
    end

    dps_interval #(.CNT_W(CNT_W)) u_interval (
        .clk       (clk),
        .rst_n     (rst_n),
        .ivl_wr    (ivl_wr),
        .ivl_wdata (ivl_wdata),
        .count_en  (idle),
        .reload    (reload),
        .tick      (tick)
    );

    dps_trigger u_trigger (
        .clk           (clk),
        .rst_n         (rst_n),
        .idle          (idle),
        .tick          (tick),
        .rx_en         (rx_en),
        .tx_en         (tx_en),
        .tx_poll_off   (tx_poll_off),
        .rx_cur_own    (rx_cur_own),
        .rx_nxt_own    (rx_nxt_own),
        .rx_ring_multi (rx_ring_multi),
        .tx_cur_own    (tx_cur_own),
        .rx_frame_done (rx_frame_done),
        .tx_frame_done (tx_frame_done),
        .tx_demand     (tx_demand),
        .launch        (launch),
        .go_rx         (go_rx),
        .go_tx         (go_tx),
        .dem_hit       (dem_hit)
    );

    dps_sequencer u_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .engine_busy (engine_busy),
        .rx_en       (rx_en),
        .launch      (launch),
        .go_rx       (go_rx),
        .go_tx       (go_tx),
        .poll_done   (poll_done),
        .idle        (idle),
        .seq_end     (seq_end),
        .poll_req    (poll_req),
        .poll_is_tx  (poll_is_tx)
    );

endmodule

// File: tb/desc_poll_sched_tb.sv
// Directed bench for desc_poll_sched: one task per scenario.
module desc_poll_sched_tb;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ivl_wr = 1'b0;
    logic [CNT_W-1:0] ivl_wdata = '0;
    logic rx_en = 1'b1, tx_en = 1'b0, tx_poll_off = 1'b0;
    logic rx_cur_own = 1'b0, rx_nxt_own = 1'b1, rx_ring_multi = 1'b0;
    logic tx_cur_own = 1'b1;
    logic rx_frame_done = 1'b0, tx_frame_done = 1'b0, tx_demand = 1'b0;
    logic engine_busy = 1'b0, poll_done = 1'b0;
    logic poll_req, poll_is_tx;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    desc_poll_sched #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ivl_wr(ivl_wr), .ivl_wdata(ivl_wdata),
        .rx_en(rx_en), .tx_en(tx_en), .tx_poll_off(tx_poll_off),
        .rx_cur_own(rx_cur_own), .rx_nxt_own(rx_nxt_own),
        .rx_ring_multi(rx_ring_multi), .tx_cur_own(tx_cur_own),
        .rx_frame_done(rx_frame_done), .tx_frame_done(tx_frame_done),
        .tx_demand(tx_demand), .engine_busy(engine_busy),
        .poll_req(poll_req), .poll_is_tx(poll_is_tx), .poll_done(poll_done)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d exp<190000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Count edges until poll_req is seen high; -1 if it never rises within maxc.
    task automatic measure(input int maxc, output int n);
        n = -1;
        for (int i = 1; i <= maxc; i++) begin
            @(posedge clk); #1;
            if (poll_req) begin
                n = i;
                return;
            end
        end
    endtask

    // Answer the outstanding request with a one-cycle done pulse.
    task automatic finish_poll();
        @(negedge clk) poll_done = 1'b1;
        @(posedge clk); #1 poll_done = 1'b0;
    endtask

    task automatic wr_ivl(input logic [CNT_W-1:0] v);
        @(negedge clk) begin ivl_wr = 1'b1; ivl_wdata = v; end
        @(negedge clk) ivl_wr = 1'b0;
    endtask

    task automatic t_reset();
        repeat (4) @(posedge clk);
        #1 check(poll_req == 1'b0, "R1 reset req", poll_req, 0);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic t_default();
        int n;
        measure(70000, n);
        check(n == 65536, "R1 default interval", n, 65536);
        check(poll_is_tx == 1'b0, "R3 timed rx poll", poll_is_tx, 0);
    endtask

    task automatic t_write();
        int n;
        wr_ivl(16'd8);
        finish_poll();
        measure(20, n);
        check(n == 8, "R2 programmed interval", n, 8);
        check(poll_is_tx == 1'b0, "R3 rx poll kind", poll_is_tx, 0);
        finish_poll();
    endtask

    task automatic t_rx_off();
        int n;
        rx_en = 1'b0;
        measure(40, n);
        check(n == -1, "R5 rx disabled no poll", n, -1);
        rx_cur_own = 1'b1;
        rx_en = 1'b1;
    endtask

    task automatic t_rx_next();
        int n;
        rx_nxt_own = 1'b0;
        rx_ring_multi = 1'b0;
        measure(30, n);
        check(n == -1, "R4 single-entry ring no poll", n, -1);
        rx_ring_multi = 1'b1;
        measure(20, n);
        check(n > 0 && n <= 8, "R4 next descriptor poll", n, 8);
        check(poll_is_tx == 1'b0, "R4 poll kind rx", poll_is_tx, 0);
        finish_poll();
        rx_nxt_own = 1'b1;
    endtask

    task automatic t_tx_timed();
        int n;
        tx_en = 1'b1; tx_cur_own = 1'b0; tx_poll_off = 1'b1;
        measure(30, n);
        check(n == -1, "R6 inhibit blocks timed tx", n, -1);
        tx_poll_off = 1'b0;
        measure(20, n);
        check(n > 0 && n <= 8, "R6 timed tx poll", n, 8);
        check(poll_is_tx == 1'b1, "R6 poll kind tx", poll_is_tx, 1);
        finish_poll();
    endtask

    task automatic t_order();
        int n;
        rx_cur_own = 1'b0;
        measure(20, n);
        check(n > 0 && poll_is_tx == 1'b0, "R8 rx first", poll_is_tx, 0);
        repeat (3) @(posedge clk);
        #1 check(poll_req == 1'b1 && poll_is_tx == 1'b0, "R11 rx request held", poll_req, 1);
        finish_poll();
        @(posedge clk); #1;
        check(poll_req == 1'b1 && poll_is_tx == 1'b1, "R8 tx after rx", poll_is_tx, 1);
        finish_poll();
        @(posedge clk); #1;
        check(poll_req == 1'b0, "R11 req drops after last done", poll_req, 0);
        rx_cur_own = 1'b1; tx_cur_own = 1'b1;
    endtask

    task automatic t_event();
        int n;
        tx_poll_off = 1'b1;
        @(negedge clk) begin tx_cur_own = 1'b0; rx_frame_done = 1'b1; end
        @(negedge clk) rx_frame_done = 1'b0;
        measure(20, n);
        check(n == -1, "R7 inhibit blocks event poll", n, -1);
        @(negedge clk) begin tx_poll_off = 1'b0; tx_frame_done = 1'b1; end
        @(posedge clk); #1 tx_frame_done = 1'b0;
        check(poll_req == 1'b1 && poll_is_tx == 1'b1, "R7 event tx poll", poll_req, 1);
        finish_poll();
        tx_cur_own = 1'b1;
    endtask

    task automatic t_demand();
        wr_ivl(16'd0);
        rx_cur_own = 1'b0; tx_cur_own = 1'b0; tx_poll_off = 1'b1;
        @(negedge clk) tx_demand = 1'b1;
        @(posedge clk); #1 tx_demand = 1'b0;
        check(poll_req == 1'b1 && poll_is_tx == 1'b0, "R9 demand rx first", poll_is_tx, 0);
        finish_poll();
        @(posedge clk); #1;
        check(poll_req == 1'b1 && poll_is_tx == 1'b1, "R9 demand tx despite inhibit", poll_is_tx, 1);
        finish_poll();
        rx_cur_own = 1'b1;
        @(negedge clk) tx_demand = 1'b1;
        @(posedge clk); #1 tx_demand = 1'b0;
        check(poll_req == 1'b1 && poll_is_tx == 1'b1, "R9 demand tx only", poll_is_tx, 1);
        finish_poll();
    endtask

    task automatic t_busy();
        @(negedge clk) engine_busy = 1'b1;
        @(negedge clk) tx_demand = 1'b1;
        @(negedge clk) tx_demand = 1'b0;
        repeat (10) @(posedge clk);
        #1 check(poll_req == 1'b0, "R10 no poll while busy", poll_req, 0);
        @(negedge clk) engine_busy = 1'b0;
        @(posedge clk); #1;
        check(poll_req == 1'b1 && poll_is_tx == 1'b1, "R10 pending demand served", poll_req, 1);
        finish_poll();
    endtask

    initial begin
        t_reset();
        t_default();
        t_write();
        t_rx_off();
        t_rx_next();
        t_tx_timed();
        t_order();
        t_event();
        t_demand();
        t_busy();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule